// File: doc/BRIEF.md
# Windowed Local Mean and Variance Unit

This block produces the local statistics a noise-reduction filter needs for one 3x3 neighbourhood at a time. Software loads nine pixel slots, pulses `start`, and after a fixed latency reads back the integer mean and variance of the window from two result registers. A third register is a running noise total. Software initialises it once before it walks the image, and the block adds each new variance into it. Software reads it once after the last window.

The arithmetic is split over four clocked stages so that no stage holds more than one wide operation. The stages are a reduction to a sum and a sum of squares, two divisions by the tap count, a squaring of the mean, and a final subtraction and accumulate. Partial results travel between stages in internal registers that have no port. A small controller sequences the stages. Its states are `ST_IDLE`, `ST_SUM`, `ST_DIV`, `ST_SQR` and `ST_OUT`. An accepted start moves `ST_IDLE` to `ST_SUM`. The controller then steps unconditionally through `ST_SUM` to `ST_DIV`, `ST_DIV` to `ST_SQR`, `ST_SQR` to `ST_OUT`, and `ST_OUT` back to `ST_IDLE`. The step out of `ST_OUT` writes the results and raises `done`.

Top module: `window_stats_unit`

## Requirements
- R1: After reset, `busy` and `done` are low and `mean_o`, `var_o` and `noise_o` read zero.
- R2: A `pix_wr` pulse while idle stores `pix_wdata` in slot `pix_idx`. Slot k is row*3+col of the window. An index of 9 or higher is ignored, and so is any pixel write while `busy` is high.
- R3: `mean_o` is the sum of the nine 8-bit unsigned pixels divided by 9 and truncated, zero-extended to 32 bits.
- R4: `var_o` is the sum of the nine squared pixels divided by 9 and truncated, minus the square of the truncated mean, as a signed 32-bit value.
- R5: Each completed computation adds its variance into `noise_o`, modulo 2^32.
- R6: An `acc_wr` pulse while idle loads `acc_wdata` into the noise register. The pulse is ignored while `busy` is high.
- R7: `done` is a one-cycle pulse. It is seen exactly five clock edges after the edge that accepted `start`, and the new results are visible in the same cycle. A start on the `done` cycle is accepted.
- R8: `busy` is high for the four cycles after an accepted start. A `start` while `busy` is high is ignored.
- R9: `mean_o` and `var_o` hold their values from one completion to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_wr | input | 1 | Pixel slot write strobe |
| pix_idx | input | 4 | Pixel slot index, row*3+col |
| pix_wdata | input | 8 | Pixel value to store |
| acc_wr | input | 1 | Noise register load strobe |
| acc_wdata | input | 32 | Value loaded into the noise register |
| start | input | 1 | Launch one computation |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| mean_o | output | 32 | Local mean result |
| var_o | output | 32 | Local variance result, signed |
| noise_o | output | 32 | Running noise total |

## Verification
An all-255 window drives the sum of squares to its widest value. A divider whose reciprocal is too short, or that has no correction step, returns a mean or mean-square one too low there, and mixed random windows catch the same fault at other values. Alternating 0 and 255 pixels give the largest variance. A design that squares before truncating, or that loses a bit in the subtraction, reports the wrong value there. Starts, pixel writes and accumulator writes sent while the unit is busy must leave the window, the timing and the total untouched. A design that fails to gate them shows a second done pulse or shifted results. The bench also checks an out-of-range slot write, accumulator wrap-around, and a start that arrives on the done cycle, which a controller with a spare recovery state would drop.

// File: rtl/wsu_pkg.sv
package wsu_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SUM  = 3'd1,
        ST_DIV  = 3'd2,
        ST_SQR  = 3'd3,
        ST_OUT  = 3'd4
    } wsu_state_e;

endpackage

// File: rtl/wsu_pixel_regs.sv
module wsu_pixel_regs #(
    parameter int PIX_W = 8,
    parameter int TAPS  = 9,
    parameter int IDX_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [PIX_W-1:0]      wr_data,
    output logic [TAPS*PIX_W-1:0] pix_flat
);

    // One register per window position; an index that matches no slot
    // writes nothing.
    for (genvar t = 0; t < TAPS; t++) begin : g_slot
        logic [PIX_W-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(t))) begin
                slot_q <= wr_data;
            end
        end
        assign pix_flat[t*PIX_W +: PIX_W] = slot_q;
    end

endmodule

// File: rtl/wsu_reduce.sv
module wsu_reduce #(
    parameter int PIX_W = 8,
    parameter int TAPS  = 9,
    parameter int SUM_W = 12,
    parameter int SQ_W  = 20
) (
    input  logic [TAPS*PIX_W-1:0] pix_flat,
    output logic [SUM_W-1:0]      sum,
    output logic [SQ_W-1:0]       sq_sum
);

    always_comb begin
        logic [SQ_W-1:0] p;
        sum    = '0;
        sq_sum = '0;
        for (int t = 0; t < TAPS; t++) begin
            p      = SQ_W'(pix_flat[t*PIX_W +: PIX_W]);
            sum    = sum + SUM_W'(pix_flat[t*PIX_W +: PIX_W]);
            sq_sum = sq_sum + p * p;
        end
    end

endmodule

// File: rtl/wsu_divconst.sv
module wsu_divconst #(
    parameter int IN_W    = 20,
    parameter int DIVISOR = 9
) (
    input  logic [IN_W-1:0] x,
    output logic [IN_W-1:0] q
);

    // Reciprocal with one spare bit of precision: the estimate is never
    // high and at most one below the exact quotient.
    localparam int SH    = IN_W + 1;
    localparam int PR_W  = IN_W + SH;
    localparam int REM_W = IN_W + 4;
    localparam logic [SH-1:0] RECIP = SH'((64'd1 << SH) / 64'(DIVISOR));

    logic [PR_W-1:0]  prod;
    logic [IN_W-1:0]  est;
    logic [REM_W-1:0] rem;

    assign prod = PR_W'(x) * PR_W'(RECIP);
    assign est  = IN_W'(prod >> SH);
    assign rem  = REM_W'(x) - REM_W'(est) * REM_W'(DIVISOR);
    assign q    = (rem >= REM_W'(DIVISOR)) ? est + IN_W'(1) : est;

endmodule

// File: rtl/window_stats_unit.sv
module window_stats_unit
    import wsu_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int WIN   = 3,
    parameter int OUT_W = 32,
    localparam int TAPS  = WIN * WIN,
    localparam int IDX_W = $clog2(TAPS) < 1 ? 1 : $clog2(TAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_wr,
    input  logic [IDX_W-1:0] pix_idx,
    input  logic [PIX_W-1:0] pix_wdata,
    input  logic             acc_wr,
    input  logic [OUT_W-1:0] acc_wdata,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic [OUT_W-1:0] mean_o,
    output logic [OUT_W-1:0] var_o,
    output logic [OUT_W-1:0] noise_o
);

    localparam int SUM_W = PIX_W + $clog2(TAPS);
    localparam int SQ_W  = 2 * PIX_W + $clog2(TAPS);

    wsu_state_e state_q, state_d;

    logic                  idle;
    logic [TAPS*PIX_W-1:0] pix_flat;
    logic [SUM_W-1:0]      sum_c;
    logic [SQ_W-1:0]       sq_c;
    logic [SUM_W-1:0]      mean_c;
    logic [SQ_W-1:0]       msq_c;

    // Hidden inter-stage registers.
    logic [SUM_W-1:0]      sum_q;
    logic [SQ_W-1:0]       sq_q;
    logic [SUM_W-1:0]      mean_q;
    logic [SQ_W-1:0]       msq_q;
    logic [SQ_W-1:0]       mean_sq_q;

    logic [OUT_W-1:0]      mean_r, var_r, noise_r;
    logic                  done_r;
    logic [OUT_W-1:0]      var_c;

    assign idle = (state_q == ST_IDLE);

    wsu_pixel_regs #(
        .PIX_W (PIX_W),
        .TAPS  (TAPS),
        .IDX_W (IDX_W)
    ) u_pix (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (pix_wr && idle),
        .wr_idx   (pix_idx),
        .wr_data  (pix_wdata),
        .pix_flat (pix_flat)
    );

    wsu_reduce #(
        .PIX_W (PIX_W),
        .TAPS  (TAPS),
        .SUM_W (SUM_W),
        .SQ_W  (SQ_W)
    ) u_reduce (
        .pix_flat (pix_flat),
        .sum      (sum_c),
        .sq_sum   (sq_c)
    );

    wsu_divconst #(
        .IN_W    (SUM_W),
        .DIVISOR (TAPS)
    ) u_div_mean (
        .x (sum_q),
        .q (mean_c)
    );

    wsu_divconst #(
        .IN_W    (SQ_W),
        .DIVISOR (TAPS)
    ) u_div_msq (
        .x (sq_q),
        .q (msq_c)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_SUM;
            ST_SUM:  state_d = ST_DIV;
            ST_DIV:  state_d = ST_SQR;
            ST_SQR:  state_d = ST_OUT;
            ST_OUT:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign var_c = OUT_W'(msq_q) - OUT_W'(mean_sq_q);

    // Stage registers and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q     <= '0;
            sq_q      <= '0;
            mean_q    <= '0;
            msq_q     <= '0;
            mean_sq_q <= '0;
            mean_r    <= '0;
            var_r     <= '0;
            noise_r   <= '0;
            done_r    <= 1'b0;
        end else begin
            done_r <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (acc_wr) noise_r <= acc_wdata;
                end
                ST_SUM: begin
                    sum_q <= sum_c;
                    sq_q  <= sq_c;
                end
                ST_DIV: begin
                    mean_q <= mean_c;
                    msq_q  <= msq_c;
                end
                ST_SQR: begin
                    mean_sq_q <= SQ_W'(mean_q) * SQ_W'(mean_q);
                end
                ST_OUT: begin
                    mean_r  <= OUT_W'(mean_q);
                    var_r   <= var_c;
                    noise_r <= noise_r + var_c;
                    done_r  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy    = !idle;
    assign done    = done_r;
    assign mean_o  = mean_r;
    assign var_o   = var_r;
    assign noise_o = noise_r;

endmodule

// File: rtl/wsu_checker.sv
module wsu_checker #(
    parameter int OUT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             acc_wr,
    input logic             busy,
    input logic             done,
    input logic [OUT_W-1:0] mean_o,
    input logic [OUT_W-1:0] var_o,
    input logic [OUT_W-1:0] noise_o
);

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start && !busy, 5)); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8

    AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R8

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(mean_o) && $stable(var_o))); // R9

    AST_NOISE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !$past(acc_wr && !busy)) |-> $stable(noise_o)); // R6

    AST_VAR_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !var_o[OUT_W-1]); // R4

    AST_MEAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mean_o <= OUT_W'(255))); // R3

endmodule

bind window_stats_unit wsu_checker #(.OUT_W(OUT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .acc_wr  (acc_wr),
    .busy    (busy),
    .done    (done),
    .mean_o  (mean_o),
    .var_o   (var_o),
    .noise_o (noise_o)
);

// File: tb/window_stats_unit_tb.sv
`timescale 1ns/1ps
module window_stats_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_wr = 1'b0;
    logic [3:0]  pix_idx = '0;
    logic [7:0]  pix_wdata = '0;
    logic        acc_wr = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic        start = 1'b0;
    logic        busy, done;
    logic [31:0] mean_o, var_o, noise_o;

    int checks = 0;
    int failures = 0;
    bit reported = 0;

    always #2.5 clk = ~clk;

    window_stats_unit u_dut (
        .clk(clk), .rst_n(rst_n), .pix_wr(pix_wr), .pix_idx(pix_idx),
        .pix_wdata(pix_wdata), .acc_wr(acc_wr), .acc_wdata(acc_wdata),
        .start(start), .busy(busy), .done(done), .mean_o(mean_o),
        .var_o(var_o), .noise_o(noise_o)
    );

    // Behavioural reference model, stepped on every rising edge.
    logic [7:0]  m_pix [9];
    logic [31:0] m_mean, m_var, m_noise;
    logic        m_done, m_busy;
    int          m_cnt;
    int          m_sum, m_sq;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 9; k++) m_pix[k] = 8'd0;
            m_mean = 0; m_var = 0; m_noise = 0;
            m_done = 0; m_cnt = 0; m_sum = 0; m_sq = 0;
        end else begin
            m_done = 0;
            if (m_cnt == 0) begin
                if (pix_wr && pix_idx < 9) m_pix[pix_idx] = pix_wdata;
                if (acc_wr) m_noise = acc_wdata;
                if (start) begin
                    m_sum = 0; m_sq = 0;
                    for (int k = 0; k < 9; k++) begin
                        m_sum += int'(m_pix[k]);
                        m_sq  += int'(m_pix[k]) * int'(m_pix[k]);
                    end
                    m_cnt = 4;
                end
            end else begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin
                    m_mean  = 32'(m_sum / 9);
                    m_var   = 32'((m_sq / 9) - (m_sum / 9) * (m_sum / 9));
                    m_noise = m_noise + m_var;
                    m_done  = 1;
                end
            end
        end
        m_busy = (m_cnt != 0);
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check("R8 busy", 32'(busy), 32'(m_busy));
            check("R7 done", 32'(done), 32'(m_done));
            check("R3 mean", mean_o, m_mean);
            check("R4 variance", var_o, m_var);
            check("R5 noise", noise_o, m_noise);
        end
    end

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        report();
    end

    task automatic wr_pix(int i, int v);
        pix_wr = 1; pix_idx = 4'(i); pix_wdata = 8'(v);
        @(negedge clk);
        pix_wr = 0;
    endtask

    task automatic wr_acc(logic [31:0] v);
        acc_wr = 1; acc_wdata = v;
        @(negedge clk);
        acc_wr = 0;
    endtask

    task automatic fire();
        start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic run_const(int v);
        for (int k = 0; k < 9; k++) wr_pix(k, v);
        fire();
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check("R1 busy", 32'(busy), 0);
        check("R1 done", 32'(done), 0);
        check("R1 mean", mean_o, 0);
        check("R1 var", var_o, 0);
        check("R1 noise", noise_o, 0);

        // R6: initialise accumulator, R3/R4 all-zero window
        wr_acc(32'd0);
        run_const(0);
        check("R3 all-0 mean", mean_o, 0);
        run_const(255);
        check("R3 all-255 mean", mean_o, 255);
        check("R4 all-255 var", var_o, 0);

        // R4: alternating extremes, largest variance
        for (int k = 0; k < 9; k++) wr_pix(k, (k % 2 == 0) ? 255 : 0);
        fire();
        repeat (5) @(negedge clk);
        check("R4 alternating var", var_o, 32'(65025*5/9 - (1275/9)*(1275/9)));

        // R2: out-of-range index ignored
        for (int k = 0; k < 9; k++) wr_pix(k, 0);
        wr_pix(9, 255);
        wr_pix(15, 200);
        fire();
        repeat (5) @(negedge clk);
        check("R2 bad index mean", mean_o, 0);

        // R8/R2/R6: start, pixel and accumulator writes while busy ignored
        for (int k = 0; k < 9; k++) wr_pix(k, 10 * k);
        fire();
        start = 1; @(negedge clk); start = 0;
        wr_pix(4, 250);
        wr_acc(32'hDEAD_BEEF);
        repeat (2) @(negedge clk);
        check("R8 busy after ignored start", 32'(busy), 0);
        check("R2 busy write mean", mean_o, 32'(360 / 9));
        // R9: results hold while idle
        repeat (4) @(negedge clk);
        check("R9 hold mean", mean_o, 32'(40));
        fire();
        repeat (5) @(negedge clk);
        check("R2 slot4 unchanged", mean_o, 32'(40));

        // R7: start on the done cycle accepted (back-to-back)
        fire();
        repeat (4) @(negedge clk);
        check("R7 done seen", 32'(done), 1);
        start = 1; @(negedge clk); start = 0;
        check("R7 back-to-back busy", 32'(busy), 1);
        repeat (5) @(negedge clk);

        // R5: accumulator wrap-around
        wr_acc(32'hFFFF_FFF0);
        for (int k = 0; k < 9; k++) wr_pix(k, (k % 2 == 0) ? 255 : 0);
        fire();
        repeat (5) @(negedge clk);
        check("R5 wrap", noise_o, 32'hFFFF_FFF0 + 32'(65025*5/9 - 141*141));

        // Random windows against the model
        wr_acc(32'd0);
        for (int n = 0; n < 300; n++) begin
            for (int k = 0; k < 9; k++) wr_pix(k, int'($urandom_range(0, 255)));
            fire();
            repeat (int'($urandom_range(4, 7))) @(negedge clk);
        end
        repeat (8) @(negedge clk);
        report();
    end

endmodule